// File: doc/BRIEF.md
# Dispatch Class Router

This block sits between register renaming and the scheduling structures of an out-of-order core. Each cycle it receives a bundle of up to `W` renamed instructions. Each slot carries a valid bit and a set of class flags. The block walks the slots in order and decides where each one goes: the scheduler queue, the load queue, the store queue, a separate non-speculative insert port, or straight to completion as a tail advance. The routing outputs are per-slot strobes, produced in the same cycle as the bundle.

The scheduler queue reports its number of free entries. Every non-squashed instruction that is dispatched takes one of those entries, so the block recomputes fullness slot by slot. The first non-squashed slot that finds no entry left halts the walk. That slot and every later slot are abandoned. In that cycle the block raises a block request towards its own control and a stall towards rename. Event counters record squashed drops, full events and each kind of dispatch.

Top module: `disp_router`

## Requirements
- R1: Slots are taken in order from slot 0 upward. A valid slot with the squash flag set that is reached before any halt is dropped with no strobe, and it adds one to the squashed-drop counter.
- R2: If a valid, non-squashed slot is reached with no free scheduler entry left, `block_o` and `stall_o` are 1 in that cycle. No strobe is raised for that slot or for any later slot, and later squashed slots are not counted.
- R3: Every dispatched valid, non-squashed slot uses one free entry. This covers plain, load, store, non-speculative, nop and pre-executed slots. The number of dispatched slots never exceeds `iq_free_i`.
- R4: A load raises both its `lq_ins_o` bit and its `iq_ins_o` bit. A store raises both its `sq_ins_o` bit and its `iq_ins_o` bit.
- R5: Class priority, from highest to lowest, is: squash, no free entry, load, store, non-speculative, nop, already executed, plain.
- R6: A non-speculative slot raises `ns_ins_o` and `can_commit_o` for that slot. It does not raise `iq_ins_o`.
- R7: A nop slot raises `tail_adv_o` and `can_commit_o` for that slot, with no insert strobe of any kind.
- R8: A slot that arrives flagged executed, with no load, store, non-speculative or nop flag, raises `exec_err_o`. It is completed as a tail advance with `can_commit_o` set.
- R9: On each clock edge the counters add up the cycle's strobes. The dispatch counter counts `iq_ins_o` bits, and the load, store and non-speculative counters count their own strobes. The full counter adds 1 for each cycle with `block_o`, and the squashed counter adds the dropped slots.
- R10: While `rst_ni` is low, all counters are 0.
- R11: A slot with its valid bit clear produces no strobe, uses no entry and never causes a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | W | Slot holds an instruction |
| squash_i | input | W | Slot instruction is squashed |
| load_i | input | W | Slot is a load |
| store_i | input | W | Slot is a store |
| nspec_i | input | W | Slot is non-speculative |
| nop_i | input | W | Slot is a nop |
| exec_i | input | W | Slot arrives already executed |
| iq_free_i | input | $clog2(IQ_DEPTH+1) | Free scheduler entries this cycle |
| iq_ins_o | output | W | Normal scheduler insert strobe |
| lq_ins_o | output | W | Load queue reserve strobe |
| sq_ins_o | output | W | Store queue reserve strobe |
| ns_ins_o | output | W | Non-speculative insert strobe |
| tail_adv_o | output | W | Tail advance, no insert |
| can_commit_o | output | W | Mark slot as able to commit |
| exec_err_o | output | 1 | Pre-executed instruction seen |
| block_o | output | 1 | Dispatch halted on full queue |
| stall_o | output | 1 | Stall request to rename |
| cnt_disp_o | output | CNT_W | Scheduler inserts counted |
| cnt_load_o | output | CNT_W | Loads dispatched |
| cnt_store_o | output | CNT_W | Stores dispatched |
| cnt_nspec_o | output | CNT_W | Non-speculative dispatched |
| cnt_squash_o | output | CNT_W | Squashed slots dropped |
| cnt_full_o | output | CNT_W | Full events |

## Verification
Routing by class and the halt on a full queue can both happen in one cycle. Several bundles mix loads, nops, non-speculative and squashed slots with a free count smaller than the number of slots. The halt then lands partway through a mixed bundle. For each such bundle the checks confirm three things: the strobes before the halt point follow the class priority, nothing appears after it, and the counters on the next edge match both the partial dispatch and the single full event.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [2:0] {
    RT_NONE, RT_PLAIN, RT_LOAD, RT_STORE, RT_NSPEC, RT_NOP, RT_EXEC
  } route_e;
endpackage

// File: rtl/disp_slot_decode.sv
module disp_slot_decode
  import disp_pkg::*;
(
  input  logic   valid_i,
  input  logic   squash_i,
  input  logic   load_i,
  input  logic   store_i,
  input  logic   nspec_i,
  input  logic   nop_i,
  input  logic   exec_i,
  output route_e route_o,
  output logic   need_o,
  output logic   drop_o
);
  assign need_o = valid_i & ~squash_i;
  assign drop_o = valid_i & squash_i;

  always_comb begin
    if (!need_o)      route_o = RT_NONE;
    else if (load_i)  route_o = RT_LOAD;
    else if (store_i) route_o = RT_STORE;
    else if (nspec_i) route_o = RT_NSPEC;
    else if (nop_i)   route_o = RT_NOP;
    else if (exec_i)  route_o = RT_EXEC;
    else              route_o = RT_PLAIN;
  end
endmodule

// File: rtl/disp_free_scan.sv
module disp_free_scan #(
  parameter int W      = 4,
  parameter int FREE_W = 5
) (
  input  logic [W-1:0]      need_i,
  input  logic [W-1:0]      drop_i,
  input  logic [FREE_W-1:0] free_i,
  output logic [W-1:0]      take_o,
  output logic [W-1:0]      drop_o,
  output logic              halt_o
);
  logic [FREE_W-1:0] rem;
  logic              halted;

  always_comb begin
    rem    = free_i;
    halted = 1'b0;
    take_o = '0;
    drop_o = '0;
    for (int i = 0; i < W; i++) begin
      if (!halted) begin
        if (drop_i[i]) begin
          drop_o[i] = 1'b1;
        end else if (need_i[i]) begin
          if (rem == '0) begin
            halted = 1'b1;
          end else begin
            take_o[i] = 1'b1;
            rem       = rem - 1'b1;
          end
        end
      end
    end
    halt_o = halted;
  end
endmodule

// File: rtl/disp_ctr.sv
module disp_ctr #(
  parameter int CNT_W = 16,
  parameter int INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + CNT_W'(inc_i);
  end
endmodule

// File: rtl/disp_router.sv
module disp_router
  import disp_pkg::*;
#(
  parameter int W        = 4,
  parameter int IQ_DEPTH = 16,
  parameter int CNT_W    = 16,
  localparam int FREE_W  = $clog2(IQ_DEPTH + 1),
  localparam int INC_W   = $clog2(W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      valid_i,
  input  logic [W-1:0]      squash_i,
  input  logic [W-1:0]      load_i,
  input  logic [W-1:0]      store_i,
  input  logic [W-1:0]      nspec_i,
  input  logic [W-1:0]      nop_i,
  input  logic [W-1:0]      exec_i,
  input  logic [FREE_W-1:0] iq_free_i,
  output logic [W-1:0]      iq_ins_o,
  output logic [W-1:0]      lq_ins_o,
  output logic [W-1:0]      sq_ins_o,
  output logic [W-1:0]      ns_ins_o,
  output logic [W-1:0]      tail_adv_o,
  output logic [W-1:0]      can_commit_o,
  output logic              exec_err_o,
  output logic              block_o,
  output logic              stall_o,
  output logic [CNT_W-1:0]  cnt_disp_o,
  output logic [CNT_W-1:0]  cnt_load_o,
  output logic [CNT_W-1:0]  cnt_store_o,
  output logic [CNT_W-1:0]  cnt_nspec_o,
  output logic [CNT_W-1:0]  cnt_squash_o,
  output logic [CNT_W-1:0]  cnt_full_o
);
  route_e       route [W];
  logic [W-1:0] need, drop, take, dropped, err_vec;
  logic         halt;

  for (genvar g = 0; g < W; g++) begin : g_slot
    disp_slot_decode u_dec (
      .valid_i (valid_i[g]),
      .squash_i(squash_i[g]),
      .load_i  (load_i[g]),
      .store_i (store_i[g]),
      .nspec_i (nspec_i[g]),
      .nop_i   (nop_i[g]),
      .exec_i  (exec_i[g]),
      .route_o (route[g]),
      .need_o  (need[g]),
      .drop_o  (drop[g])
    );

    always_comb begin
      iq_ins_o[g]     = 1'b0;
      lq_ins_o[g]     = 1'b0;
      sq_ins_o[g]     = 1'b0;
      ns_ins_o[g]     = 1'b0;
      tail_adv_o[g]   = 1'b0;
      can_commit_o[g] = 1'b0;
      err_vec[g]      = 1'b0;
      if (take[g]) begin
        unique case (route[g])
          RT_LOAD:  begin iq_ins_o[g] = 1'b1; lq_ins_o[g] = 1'b1; end
          RT_STORE: begin iq_ins_o[g] = 1'b1; sq_ins_o[g] = 1'b1; end
          RT_NSPEC: begin ns_ins_o[g] = 1'b1; can_commit_o[g] = 1'b1; end
          RT_NOP:   begin tail_adv_o[g] = 1'b1; can_commit_o[g] = 1'b1; end
          RT_EXEC:  begin
            tail_adv_o[g] = 1'b1; can_commit_o[g] = 1'b1; err_vec[g] = 1'b1;
          end
          RT_PLAIN: iq_ins_o[g] = 1'b1;
          default:  ;
        endcase
      end
    end
  end

  disp_free_scan #(.W(W), .FREE_W(FREE_W)) u_scan (
    .need_i(need),
    .drop_i(drop),
    .free_i(iq_free_i),
    .take_o(take),
    .drop_o(dropped),
    .halt_o(halt)
  );

  assign exec_err_o = |err_vec;
  assign block_o    = halt;
  assign stall_o    = halt;

  function automatic logic [INC_W-1:0] pop(input logic [W-1:0] v);
    pop = '0;
    for (int i = 0; i < W; i++) pop = pop + INC_W'(v[i]);
  endfunction

  disp_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_c_disp (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pop(iq_ins_o)), .cnt_o(cnt_disp_o));
  disp_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_c_load (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pop(lq_ins_o)), .cnt_o(cnt_load_o));
  disp_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_c_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pop(sq_ins_o)), .cnt_o(cnt_store_o));
  disp_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_c_nspec (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pop(ns_ins_o)), .cnt_o(cnt_nspec_o));
  disp_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_c_squash (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pop(dropped)), .cnt_o(cnt_squash_o));
  disp_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_c_full (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(INC_W'(halt)), .cnt_o(cnt_full_o));
endmodule

// File: rtl/disp_router_chk.sv
module disp_router_chk #(
  parameter int W      = 4,
  parameter int FREE_W = 5,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FREE_W-1:0] iq_free_i,
  input logic [W-1:0]      iq_ins_o,
  input logic [W-1:0]      lq_ins_o,
  input logic [W-1:0]      sq_ins_o,
  input logic [W-1:0]      ns_ins_o,
  input logic [W-1:0]      tail_adv_o,
  input logic [W-1:0]      can_commit_o,
  input logic              exec_err_o,
  input logic              block_o,
  input logic [CNT_W-1:0]  cnt_full_o
);
  // R4
  mem_in_iq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lq_ins_o | sq_ins_o) & ~iq_ins_o) == '0);

  // R6
  nspec_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_ins_o & (iq_ins_o | tail_adv_o)) == '0);

  // R3
  take_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(iq_ins_o | ns_ins_o | tail_adv_o) <= int'(iq_free_i));

  // R2
  block_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> $countones(iq_ins_o | ns_ins_o | tail_adv_o) == int'(iq_free_i));

  // R9
  full_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |=> cnt_full_o == CNT_W'($past(cnt_full_o) + 1'b1));

  // R8
  exec_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_err_o |-> (tail_adv_o & can_commit_o) != '0);
endmodule

bind disp_router disp_router_chk #(.W(W), .FREE_W(FREE_W), .CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .iq_free_i(iq_free_i),
  .iq_ins_o(iq_ins_o), .lq_ins_o(lq_ins_o), .sq_ins_o(sq_ins_o),
  .ns_ins_o(ns_ins_o), .tail_adv_o(tail_adv_o), .can_commit_o(can_commit_o),
  .exec_err_o(exec_err_o), .block_o(block_o), .cnt_full_o(cnt_full_o)
);

// File: tb/disp_router_tb_top.sv
module disp_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int FREE_W = 5;
  localparam int CNT_W = 16;

  logic clk = 0, rst_ni = 0;
  logic [W-1:0] valid, squash, load, store, nspec, nop, exec;
  logic [FREE_W-1:0] free;
  logic [W-1:0] iq_ins, lq_ins, sq_ins, ns_ins, tail_adv, can_commit;
  logic exec_err, block, stall;
  logic [CNT_W-1:0] c_disp, c_load, c_store, c_nspec, c_squash, c_full;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_router #(.W(W), .IQ_DEPTH(16), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .squash_i(squash),
    .load_i(load), .store_i(store), .nspec_i(nspec), .nop_i(nop), .exec_i(exec),
    .iq_free_i(free), .iq_ins_o(iq_ins), .lq_ins_o(lq_ins), .sq_ins_o(sq_ins),
    .ns_ins_o(ns_ins), .tail_adv_o(tail_adv), .can_commit_o(can_commit),
    .exec_err_o(exec_err), .block_o(block), .stall_o(stall),
    .cnt_disp_o(c_disp), .cnt_load_o(c_load), .cnt_store_o(c_store),
    .cnt_nspec_o(c_nspec), .cnt_squash_o(c_squash), .cnt_full_o(c_full));

  typedef struct packed {
    logic [3:0] v, sq, ld, st, ns, np, ex;
    logic [4:0] fr;
    logic [3:0] e_iq, e_lq, e_sq, e_ns, e_tl, e_cc;
    logic       e_blk, e_err;
    logic [2:0] e_sqc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R1 plain bundle, all in order
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,5'd8, 4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,3'd0},
    // R4 R6 R7 one of each class
    '{4'hF,4'h0,4'h1,4'h2,4'h4,4'h8,4'h0,5'd8, 4'h3,4'h1,4'h2,4'h4,4'h8,4'hC,1'b0,1'b0,3'd0},
    // R1 squashed drops
    '{4'hF,4'h5,4'h0,4'h0,4'h0,4'h0,4'h0,5'd8, 4'hA,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,3'd2},
    // R2 halt mid-bundle
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,5'd2, 4'h3,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,3'd0},
    // R2 R3 squashed slot before the halt counts
    '{4'hF,4'h4,4'h8,4'h0,4'h0,4'h0,4'h0,5'd2, 4'h3,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,3'd1},
    // R2 halt at slot 1, later squashed not counted
    '{4'hF,4'h5,4'h0,4'h0,4'h0,4'h0,4'h0,5'd0, 4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,3'd1},
    // R5 load over store, store over nspec/nop
    '{4'h3,4'h0,4'h1,4'h3,4'h3,4'h3,4'h0,5'd4, 4'h3,4'h1,4'h2,4'h0,4'h0,4'h0,1'b0,1'b0,3'd0},
    // R5 nspec over nop
    '{4'h3,4'h0,4'h0,4'h0,4'h1,4'h3,4'h0,5'd4, 4'h0,4'h0,4'h0,4'h1,4'h2,4'h3,1'b0,1'b0,3'd0},
    // R8 executed flag; load with exec is a load
    '{4'h3,4'h0,4'h2,4'h0,4'h0,4'h0,4'h3,5'd4, 4'h2,4'h2,4'h0,4'h0,4'h1,4'h1,1'b0,1'b1,3'd0},
    // R11 holes in the bundle
    '{4'h5,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,5'd8, 4'h5,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,3'd0},
    // R11 invalid slot uses no entry
    '{4'h5,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,5'd1, 4'h1,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,3'd0},
    // R5 squash beats full
    '{4'h1,4'h1,4'h1,4'h0,4'h0,4'h0,4'h0,5'd0, 4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,3'd1},
    // R11 empty bundle with no room
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,5'd0, 4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,3'd0},
    // R3 nops use entries
    '{4'h3,4'h0,4'h0,4'h0,4'h0,4'h3,4'h0,5'd1, 4'h0,4'h0,4'h0,4'h0,4'h1,4'h1,1'b1,1'b0,3'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    valid = '0; squash = '0; load = '0; store = '0;
    nspec = '0; nop = '0; exec = '0; free = '0;
  endtask

  int x_disp = 0, x_load = 0, x_store = 0, x_nspec = 0, x_sq = 0, x_full = 0;

  initial begin
    drive_idle();
    #(CLK_PERIOD*2);
    // R10 counters in reset
    check("R10 disp", c_disp, 0);
    check("R10 full", c_full, 0);
    check("R10 squash", c_squash, 0);
    @(negedge clk); rst_ni = 1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      valid = VECS[k].v; squash = VECS[k].sq; load = VECS[k].ld;
      store = VECS[k].st; nspec = VECS[k].ns; nop = VECS[k].np;
      exec = VECS[k].ex; free = VECS[k].fr;
      #(CLK_PERIOD/4);
      check("R1 R4 iq_ins", iq_ins, VECS[k].e_iq);
      check("R4 lq_ins", lq_ins, VECS[k].e_lq);
      check("R4 sq_ins", sq_ins, VECS[k].e_sq);
      check("R6 ns_ins", ns_ins, VECS[k].e_ns);
      check("R7 tail_adv", tail_adv, VECS[k].e_tl);
      check("R6 R7 can_commit", can_commit, VECS[k].e_cc);
      check("R2 block", block, VECS[k].e_blk);
      check("R2 stall", stall, VECS[k].e_blk);
      check("R8 exec_err", exec_err, VECS[k].e_err);
      x_disp  += $countones(VECS[k].e_iq);
      x_load  += $countones(VECS[k].e_lq);
      x_store += $countones(VECS[k].e_sq);
      x_nspec += $countones(VECS[k].e_ns);
      x_sq    += int'(VECS[k].e_sqc);
      x_full  += int'(VECS[k].e_blk);
      @(posedge clk); #1;
      check("R9 cnt_disp", c_disp, x_disp);
      check("R9 cnt_load", c_load, x_load);
      check("R9 cnt_store", c_store, x_store);
      check("R9 cnt_nspec", c_nspec, x_nspec);
      check("R9 cnt_squash", c_squash, x_sq);
      check("R9 cnt_full", c_full, x_full);
    end

    // R9 idle cycles leave counters unchanged
    @(negedge clk); drive_idle(); free = 5'd16;
    @(posedge clk); #1;
    check("R9 idle disp", c_disp, x_disp);
    check("R9 idle full", c_full, x_full);

    // R3 exact fit dispatches all four, no halt
    @(negedge clk); valid = 4'hF; free = 5'd4;
    #(CLK_PERIOD/4);
    check("R3 exact fit iq", iq_ins, 15);
    check("R3 exact fit block", block, 0);

    // R10 asynchronous reset clears counters
    @(negedge clk); drive_idle(); rst_ni = 0; #1;
    check("R10 reset disp", c_disp, 0);
    check("R10 reset load", c_load, 0);
    check("R10 reset full", c_full, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*5000);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule